// File: doc/BRIEF.md
# Dual-Bank Clock Crossbar with Glitch-Free Enables

This block takes two independent clocks and steers them onto two output banks, A and B. Each bank has three clock outputs. A two-bit mode input chooses the routing. Both banks can run from the same clock, each bank can run from its own clock, or the two clocks can be swapped between the banks.

Every output is a true and complement pair of single-ended signals. Each bank has an active-low enable that may change at any moment relative to the clock. The enable is resynchronised inside the domain of the clock the bank currently uses. The gate then changes only during that clock's low phase, so no shortened pulse ever appears when a bank is switched on or off. The disable and enable latencies are fixed numbers of source periods.

Changing the mode while a bank is running is outside the glitch-free guarantee. The mode should be changed only while the affected banks are disabled.

Top module: `clk_xbar_gate`

## Requirements
- R1: With mode `sel_i` = 2'b00, every output of bank A and bank B follows `clk0_i`.
- R2: With mode 2'b01, every output of both banks follows `clk1_i`.
- R3: With mode 2'b10, bank A follows `clk0_i` and bank B follows `clk1_i`.
- R4: With mode 2'b11, bank A follows `clk1_i` and bank B follows `clk0_i`.
- R5: A bank enable held at 0 (active low) leaves that bank's three true outputs equal to its source clock.
- R6: A disabled bank drives all three true outputs to 0 and all three complement outputs to 1.
- R7: Each complement output is the exact inverse of its true output at all times, in both the enabled and the disabled state.
- R8: No high or low phase on any output is shorter than half of the bank's source period, whatever the timing of enable changes.
- R9: After an enable is driven to 1, the last falling edge of the bank comes 1.5 to 2.5 source periods after the request. The outputs then stay parked.
- R10: After an enable is driven to 0, the first rising edge of the bank comes 3 to 4 source periods after the request.
- R11: While `rst_ni` is low, and after its release until the synchroniser captures the enable, both banks are parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | Source clock 0 |
| clk1_i | input | 1 | Source clock 1 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Routing mode (00 all clk0, 01 all clk1, 10 split, 11 crossed) |
| oe_a_ni | input | 1 | Bank A enable, active low, asynchronous |
| oe_b_ni | input | 1 | Bank B enable, active low, asynchronous |
| qa_o | output | 3 | Bank A true outputs |
| qa_n_o | output | 3 | Bank A complement outputs |
| qb_o | output | 3 | Bank B true outputs |
| qb_n_o | output | 3 | Bank B complement outputs |

## Verification
A wrong synchroniser depth shifts the enable or disable latency by whole source periods. The bench sees this on the first rising or last falling edge after the request, within four periods. A gate register that updates in the high phase instead of the low phase shows up as a truncated high pulse on the very edge where the enable takes effect. The pulse-width monitor catches it on the next output transition. A wrong routing entry shows up within one period as outputs that disagree with the expected source clock at mid-phase sample points.

// File: rtl/clk_xbar_pkg.sv
`timescale 1ns/1ps
package clk_xbar_pkg;
  typedef enum logic [1:0] {
    XB_ALL0  = 2'b00,
    XB_ALL1  = 2'b01,
    XB_SPLIT = 2'b10,
    XB_CROSS = 2'b11
  } xbar_mode_e;

  localparam int unsigned NUM_BANK = 2;
endpackage

// File: rtl/clk_xbar_route.sv
`timescale 1ns/1ps
module clk_xbar_route
  import clk_xbar_pkg::*;
(
  input  logic                clk0_i,
  input  logic                clk1_i,
  input  logic [1:0]          sel_i,
  output logic [NUM_BANK-1:0] bank_clk_o
);
  // index 0 = bank A, index 1 = bank B
  always_comb begin
    unique case (xbar_mode_e'(sel_i))
      XB_ALL0:  bank_clk_o = {clk0_i, clk0_i};
      XB_ALL1:  bank_clk_o = {clk1_i, clk1_i};
      XB_SPLIT: bank_clk_o = {clk1_i, clk0_i};
      XB_CROSS: bank_clk_o = {clk0_i, clk1_i};
      default:  bank_clk_o = '0;
    endcase
  end
endmodule

// File: rtl/clk_xbar_en_sync.sv
`timescale 1ns/1ps
module clk_xbar_en_sync #(
  parameter int unsigned DIS_STAGES = 2,
  parameter int unsigned EN_STAGES  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_o
);
  logic [EN_STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[EN_STAGES-2:0], en_i};
  end

  // drop after DIS_STAGES edges, rise only after EN_STAGES edges
  assign en_o = &chain_q[EN_STAGES-1:DIS_STAGES-1];
endmodule

// File: rtl/clk_xbar_bank.sv
`timescale 1ns/1ps
module clk_xbar_bank #(
  parameter int unsigned FANOUT     = 3,
  parameter int unsigned DIS_STAGES = 2,
  parameter int unsigned EN_STAGES  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_ni,
  output logic [FANOUT-1:0] q_o,
  output logic [FANOUT-1:0] q_n_o,
  output logic              gate_o
);
  logic en_sync;
  logic gate_q;
  logic gated_clk;

  clk_xbar_en_sync #(
    .DIS_STAGES(DIS_STAGES),
    .EN_STAGES (EN_STAGES)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (~oe_ni),
    .en_o  (en_sync)
  );

  // transparent only in the low phase: gate moves after a full high phase
  always_latch begin
    if (!rst_ni)     gate_q <= 1'b0;
    else if (!clk_i) gate_q <= en_sync;
  end

  assign gated_clk = clk_i & gate_q;
  assign gate_o    = gate_q;

  for (genvar i = 0; i < FANOUT; i++) begin : g_out
    assign q_o[i]   = gated_clk;
    assign q_n_o[i] = ~gated_clk;
  end
endmodule

// File: rtl/clk_xbar_gate.sv
`timescale 1ns/1ps
module clk_xbar_gate
  import clk_xbar_pkg::*;
#(
  parameter int unsigned FANOUT     = 3,
  parameter int unsigned DIS_STAGES = 2,
  parameter int unsigned EN_STAGES  = 3
) (
  input  logic              clk0_i,
  input  logic              clk1_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni,
  output logic [FANOUT-1:0] qa_o,
  output logic [FANOUT-1:0] qa_n_o,
  output logic [FANOUT-1:0] qb_o,
  output logic [FANOUT-1:0] qb_n_o
);
  logic [NUM_BANK-1:0] bank_clk;
  logic [NUM_BANK-1:0] bank_oe_n;
  logic [NUM_BANK-1:0] bank_gate;
  logic [FANOUT-1:0]   bank_q   [NUM_BANK];
  logic [FANOUT-1:0]   bank_q_n [NUM_BANK];

  assign bank_oe_n = {oe_b_ni, oe_a_ni};

  clk_xbar_route i_route (
    .clk0_i    (clk0_i),
    .clk1_i    (clk1_i),
    .sel_i     (sel_i),
    .bank_clk_o(bank_clk)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    clk_xbar_bank #(
      .FANOUT    (FANOUT),
      .DIS_STAGES(DIS_STAGES),
      .EN_STAGES (EN_STAGES)
    ) i_bank (
      .clk_i (bank_clk[b]),
      .rst_ni(rst_ni),
      .oe_ni (bank_oe_n[b]),
      .q_o   (bank_q[b]),
      .q_n_o (bank_q_n[b]),
      .gate_o(bank_gate[b])
    );
  end

  assign qa_o   = bank_q[0];
  assign qa_n_o = bank_q_n[0];
  assign qb_o   = bank_q[1];
  assign qb_n_o = bank_q_n[1];
endmodule

// File: rtl/clk_xbar_gate_chk.sv
`timescale 1ns/1ps
module clk_xbar_gate_chk #(
  parameter int unsigned FANOUT = 3
) (
  input logic              clk0_i,
  input logic              clk1_i,
  input logic              rst_ni,
  input logic [1:0]        sel_i,
  input logic [FANOUT-1:0] qa_o,
  input logic [FANOUT-1:0] qa_n_o,
  input logic [FANOUT-1:0] qb_o,
  input logic [FANOUT-1:0] qb_n_o,
  input logic [1:0]        bank_gate
);
  AST_COMPL_A: assert property (@(posedge clk0_i) disable iff (!rst_ni) qa_n_o == ~qa_o); // R7
  AST_COMPL_B: assert property (@(posedge clk1_i) disable iff (!rst_ni) qb_n_o == ~qb_o); // R7
  AST_PARK_A: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    !bank_gate[0] |-> (qa_o == '0 && qa_n_o == '1)); // R6
  AST_PARK_B: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    !bank_gate[1] |-> (qb_o == '0 && qb_n_o == '1)); // R6
  AST_ROUTE_ALL0: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (sel_i == 2'b00 && (qa_o[0] || qb_o[0])) |-> clk0_i); // R1
  AST_ROUTE_ALL1: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    (sel_i == 2'b01 && (qa_o[0] || qb_o[0])) |-> clk1_i); // R2
  AST_ROUTE_SPLIT_A: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (sel_i == 2'b10 && qa_o[0]) |-> clk0_i); // R3
  AST_ROUTE_SPLIT_B: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    (sel_i == 2'b10 && qb_o[0]) |-> clk1_i); // R3
  AST_ROUTE_CROSS_A: assert property (@(posedge clk0_i) disable iff (!rst_ni)
    (sel_i == 2'b11 && qa_o[0]) |-> clk1_i); // R4
  AST_ROUTE_CROSS_B: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (sel_i == 2'b11 && qb_o[0]) |-> clk0_i); // R4
endmodule

bind clk_xbar_gate clk_xbar_gate_chk #(.FANOUT(FANOUT)) i_chk (
  .clk0_i   (clk0_i),
  .clk1_i   (clk1_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .qa_o     (qa_o),
  .qa_n_o   (qa_n_o),
  .qb_o     (qb_o),
  .qb_n_o   (qb_n_o),
  .bank_gate(bank_gate)
);

// File: tb/test_clk_xbar_gate.sv
`timescale 1ns/1ps
module test_clk_xbar_gate;
  localparam real P0 = 20.0;  // 50 MHz
  localparam real P1 = 34.0;

  logic       clk0 = 1'b0;
  logic       clk1 = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic       oe_a_n, oe_b_n;
  logic [2:0] qa, qa_n, qb, qb_n;

  int checks = 0;
  int errors = 0;
  realtime last_edge [2] = '{0.0, 0.0};
  realtime last_fall [2] = '{0.0, 0.0};

  clk_xbar_gate i_clk_xbar_gate (
    .clk0_i (clk0),
    .clk1_i (clk1),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .oe_a_ni(oe_a_n),
    .oe_b_ni(oe_b_n),
    .qa_o   (qa),
    .qa_n_o (qa_n),
    .qb_o   (qb),
    .qb_n_o (qb_n)
  );

  always #10 clk0 = ~clk0;
  always #17 clk1 = ~clk1;

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // 0 -> clk0, 1 -> clk1, per mode table of R1..R4
  function automatic bit src_of(input int b, input logic [1:0] s);
    case (s)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return (b == 0) ? 1'b0 : 1'b1;
      default: return (b == 0) ? 1'b1 : 1'b0;
    endcase
  endfunction

  function automatic real per_of(input int b);
    return src_of(b, sel) ? P1 : P0;
  endfunction

  function automatic string mode_req(input logic [1:0] s);
    case (s)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [2:0] get_q(input int b);
    return (b == 0) ? qa : qb;
  endfunction

  function automatic logic [2:0] get_qn(input int b);
    return (b == 0) ? qa_n : qb_n;
  endfunction

  task automatic set_oe(input int b, input logic v);
    if (b == 0) oe_a_n = v;
    else        oe_b_n = v;
  endtask

  // R8 pulse width monitor
  task automatic edge_mon(input int b, input logic v);
    realtime now = $realtime;
    real w = now - last_edge[b];
    if (rst_n && last_edge[b] > 0.0)
      check(w >= per_of(b) / 2.0 - 0.01, "R8",
            $sformatf("bank %0d phase %0.3f ns, expected >= %0.3f", b, w, per_of(b) / 2.0));
    last_edge[b] = now;
    if (!v) last_fall[b] = now;
  endtask

  always @(qa[0]) edge_mon(0, qa[0]);
  always @(qb[0]) edge_mon(1, qb[0]);

  task automatic rand_wait();
    #($urandom_range(0, 40));
    #($urandom_range(1, 999) / 1000.0);
  endtask

  task automatic measure_disable(input int b);
    realtime t0;
    real T, lat;
    rand_wait();
    t0 = $realtime;
    set_oe(b, 1'b1);
    T = per_of(b);
    #(8.0 * T);
    lat = last_fall[b] - t0;
    check(lat >= 1.5 * T - 0.01 && lat <= 2.5 * T + 0.01, "R9",
          $sformatf("bank %0d stop latency %0.3f, expected %0.3f..%0.3f", b, lat, 1.5 * T, 2.5 * T));
    check(get_q(b) == 3'b000 && get_qn(b) == 3'b111, "R6",
          $sformatf("bank %0d q=%b qn=%b, expected 000/111", b, get_q(b), get_qn(b)));
  endtask

  task automatic measure_enable(input int b);
    realtime t0;
    real T, lat;
    rand_wait();
    t0 = $realtime;
    set_oe(b, 1'b0);
    T = per_of(b);
    if (b == 0) @(posedge qa[0]);
    else        @(posedge qb[0]);
    lat = $realtime - t0;
    check(lat >= 3.0 * T - 0.01 && lat <= 4.0 * T + 0.01, "R10",
          $sformatf("bank %0d start latency %0.3f, expected %0.3f..%0.3f", b, lat, 3.0 * T, 4.0 * T));
  endtask

  // samples at x.5 ns, away from every clock edge
  task automatic check_route(input int n);
    real f = $realtime - $floor($realtime);
    #(1.5 - f);
    for (int k = 0; k < n; k++) begin
      #1;
      for (int b = 0; b < 2; b++) begin
        logic e;
        logic [2:0] q, qn;
        e  = src_of(b, sel) ? clk1 : clk0;
        q  = get_q(b);
        qn = get_qn(b);
        check(q == {3{e}}, $sformatf("%s R5", mode_req(sel)),
              $sformatf("bank %0d q=%b, expected %b", b, q, {3{e}}));
        check(qn == ~q, "R7", $sformatf("bank %0d qn=%b, expected %b", b, qn, ~q));
      end
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n  = 1'b0;
    sel    = 2'b00;
    oe_a_n = 1'b0;
    oe_b_n = 1'b0;
    #1.5;
    check(qa == 3'b000 && qa_n == 3'b111 && qb == 3'b000 && qb_n == 3'b111, "R11",
          $sformatf("in reset qa=%b qa_n=%b qb=%b qb_n=%b, expected 000/111", qa, qa_n, qb, qb_n));
    #95;
    rst_n = 1'b1;  // released at 96.5 ns
    #1;
    check(qa == 3'b000 && qb == 3'b000, "R11",
          $sformatf("after release qa=%b qb=%b, expected 000", qa, qb));
    #(10.0 * P1);
    check_route(40);

    for (int it = 0; it < 10; it++) begin
      logic [1:0] m;
      case (it)
        0:       m = 2'b00;
        1:       m = 2'b10;
        2:       m = 2'b11;
        3:       m = 2'b01;
        default: m = 2'($urandom_range(0, 3));
      endcase
      measure_disable(0);
      measure_disable(1);
      #3;
      sel = m;
      #3;
      measure_enable(0);
      measure_enable(1);
      #(6.0 * P1);
      check_route(80);
    end

    // random enable toggling on bank A for R8
    for (int k = 0; k < 40; k++) begin
      #($urandom_range(1, 120));
      #($urandom_range(1, 999) / 1000.0);
      oe_a_n = ~oe_a_n;
    end
    oe_a_n = 1'b0;
    #(10.0 * P1);
    check_route(40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule